// File: doc/BRIEF.md
# One-Wire Search Branch Step

This block carries out a single bit position of the binary identifier search used on a one-wire bus. A higher-level sequencer pulses `start` and supplies the branch it would take if devices disagree. The block then asks an external time-slot engine for two read slots and gets back the true bit and the complement bit of that position from all devices still taking part. From those two bits it picks a branch direction, asks for one write slot carrying that direction, and ends with a three-bit verdict for the sequencer.

The sequencer keeps track of the last discrepancy across the identifier and builds the identifier itself. This block handles only one position per start. When both read bits come back as 1, no device answered. The block then reports the restart code at once and does not issue the write slot.

Slot requests go out on a valid/ready channel. Once `slot_req_valid` is high, the request kind and bit stay fixed until the engine raises `slot_req_ready`. Only one request is outstanding at a time. The engine ends each slot with a one-cycle `slot_rsp_valid` pulse; for read slots it also gives the sampled bus level on `slot_rsp_bit`. The block accepts that pulse in any cycle, because the response channel has no back-pressure.

Top module: `owts_search_step`

## Requirements
- R1: After reset, `busy`, `done` and `slot_req_valid` are 0 and `result` is 3'b000.
- R2: Each accepted start produces requests in a fixed order: a read slot (`slot_req_write`=0, `slot_req_bit`=1), a second read slot of the same form, and then, unless R4 applies, one write slot (`slot_req_write`=1). The first response is the true bit and the second is the complement bit.
- R3: While `slot_req_valid` is high and `slot_req_ready` is low, the request stays pending and `slot_req_write` and `slot_req_bit` hold their values. No new request is raised until the previous one has received its response.
- R4: The result layout is bit 0 = true bit, bit 1 = complement bit, bit 2 = direction taken. If both read bits are 1, the result is 3'b011, no write slot is requested, and `done` follows the second response.
- R5: If both read bits are 0, the direction is the `pref_dir` value sampled with the accepted start. The write slot carries that bit, and the result is {pref,0,0}.
- R6: If exactly one read bit is 1, the direction equals the true bit. The write slot carries it, and the result is 3'b101 (true bit 1) or 3'b010 (true bit 0).
- R7: `busy` rises in the cycle after an accepted start and stays high through the single cycle in which `done` is high. `done` is high in the cycle after the final response and is low again one cycle later.
- R8: `start` is ignored while `busy` is high. Changes on `pref_dir` after the accepted start have no effect on the step in progress. While idle, no request is raised.
- R9: While `busy` is low, `result` keeps the verdict of the last step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one search step (taken only when idle) |
| pref_dir | input | 1 | Branch to take when devices disagree |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | {direction, complement bit, true bit} |
| slot_req_valid | output | 1 | Slot request pending |
| slot_req_ready | input | 1 | Engine accepts the pending request |
| slot_req_write | output | 1 | 1 = write slot, 0 = read slot |
| slot_req_bit | output | 1 | Bit to drive (1 for read slots) |
| slot_rsp_valid | input | 1 | Slot finished (one-cycle pulse) |
| slot_rsp_bit | input | 1 | Sampled bus level for read slots |

## Verification
The bench targets the restart case. A design that still issues the write slot there would show a third request and a late `done`. It also targets the disagreement case with both preferred values, where a design that ignored `pref_dir` or sampled it late would write the wrong branch. The bench changes `pref_dir` and pulses `start` in the middle of a step, so a design that resampled either input would restart or change direction. Long ready stalls and delayed responses expose requests that change while pending, or responses that are taken before the request was accepted.

// File: rtl/owts_pkg.sv
package owts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RQ_ID,
    ST_WT_ID,
    ST_RQ_CMP,
    ST_WT_CMP,
    ST_RQ_DIR,
    ST_WT_DIR,
    ST_FIN
  } step_e;

  // packed MSB first: dir is bit 2, cmp bit 1, id bit 0
  typedef struct packed {
    logic dir;
    logic cmp;
    logic id;
  } verdict_t;

  localparam int unsigned VERDICT_W = $bits(verdict_t);

endpackage

// File: rtl/owts_decide.sv
module owts_decide
  import owts_pkg::*;
(
  input  logic     id_bit,
  input  logic     cmp_bit,
  input  logic     pref,
  output verdict_t verdict,
  output logic     no_reply
);

  always_comb begin
    verdict.id  = id_bit;
    verdict.cmp = cmp_bit;
    no_reply    = id_bit & cmp_bit;
    if (no_reply)
      verdict.dir = 1'b0;
    else if (id_bit == cmp_bit)
      verdict.dir = pref;      // both zero: devices disagree
    else
      verdict.dir = id_bit;    // only one branch populated
  end

endmodule

// File: rtl/owts_ctrl.sv
module owts_ctrl
  import owts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic no_reply,
  output logic busy,
  output logic done,
  output logic req_valid,
  output logic req_write,
  output logic load_pref,
  output logic cap_id,
  output logic cap_cmp
);

  step_e st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d      = st_q;
    load_pref = 1'b0;
    cap_id    = 1'b0;
    cap_cmp   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d      = ST_RQ_ID;
        load_pref = 1'b1;
      end
      ST_RQ_ID:  if (req_ready) st_d = ST_WT_ID;
      ST_WT_ID:  if (rsp_valid) begin
        st_d   = ST_RQ_CMP;
        cap_id = 1'b1;
      end
      ST_RQ_CMP: if (req_ready) st_d = ST_WT_CMP;
      ST_WT_CMP: if (rsp_valid) begin
        cap_cmp = 1'b1;
        st_d    = no_reply ? ST_FIN : ST_RQ_DIR;
      end
      ST_RQ_DIR: if (req_ready) st_d = ST_WT_DIR;
      ST_WT_DIR: if (rsp_valid) st_d = ST_FIN;
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign req_valid = (st_q == ST_RQ_ID) || (st_q == ST_RQ_CMP) || (st_q == ST_RQ_DIR);
  assign req_write = (st_q == ST_RQ_DIR);

endmodule

// File: rtl/owts_hold.sv
module owts_hold
  import owts_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_pref,
  input  logic     pref_in,
  input  logic     cap_id,
  input  logic     cap_cmp,
  input  logic     rsp_bit,
  input  verdict_t verdict_in,
  output logic     pref_q,
  output logic     id_q,
  output verdict_t verdict_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pref_q    <= 1'b0;
      id_q      <= 1'b0;
      verdict_q <= '0;
    end else begin
      if (load_pref) pref_q    <= pref_in;
      if (cap_id)    id_q      <= rsp_bit;
      if (cap_cmp)   verdict_q <= verdict_in;
    end
  end

endmodule

// File: rtl/owts_search_step.sv
module owts_search_step
  import owts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pref_dir,
  output logic       busy,
  output logic       done,
  output logic [2:0] result,
  output logic       slot_req_valid,
  input  logic       slot_req_ready,
  output logic       slot_req_write,
  output logic       slot_req_bit,
  input  logic       slot_rsp_valid,
  input  logic       slot_rsp_bit
);

  logic     load_pref, cap_id, cap_cmp, no_reply;
  logic     pref_q, id_q;
  verdict_t verdict_now, verdict_q;

  owts_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_ready (slot_req_ready),
    .rsp_valid (slot_rsp_valid),
    .no_reply  (no_reply),
    .busy      (busy),
    .done      (done),
    .req_valid (slot_req_valid),
    .req_write (slot_req_write),
    .load_pref (load_pref),
    .cap_id    (cap_id),
    .cap_cmp   (cap_cmp)
  );

  // decision uses the stored true bit and the live complement response
  owts_decide u_decide (
    .id_bit   (id_q),
    .cmp_bit  (slot_rsp_bit),
    .pref     (pref_q),
    .verdict  (verdict_now),
    .no_reply (no_reply)
  );

  owts_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_pref  (load_pref),
    .pref_in    (pref_dir),
    .cap_id     (cap_id),
    .cap_cmp    (cap_cmp),
    .rsp_bit    (slot_rsp_bit),
    .verdict_in (verdict_now),
    .pref_q     (pref_q),
    .id_q       (id_q),
    .verdict_q  (verdict_q)
  );

  // read slots release the line (bit 1); write slot carries the direction
  assign slot_req_bit = slot_req_write ? verdict_q.dir : 1'b1;
  assign result       = verdict_q;

endmodule

// File: rtl/owts_search_step_chk.sv
module owts_search_step_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [2:0] result,
  input logic       slot_req_valid,
  input logic       slot_req_ready,
  input logic       slot_req_write,
  input logic       slot_req_bit
);

  logic [1:0] acc_cnt;
  logic       wr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      wr_bit  <= 1'b0;
    end else if (!busy && start) begin
      acc_cnt <= '0;
    end else if (slot_req_valid && slot_req_ready) begin
      acc_cnt <= acc_cnt + 2'd1;
      if (slot_req_write) wr_bit <= slot_req_bit;
    end
  end

  // R2
  rd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req_valid && slot_req_ready && acc_cnt < 2'd2 |-> !slot_req_write && slot_req_bit);
  // R2
  wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req_valid && slot_req_ready && acc_cnt == 2'd2 |-> slot_req_write);
  // R3
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req_valid && !slot_req_ready |=> slot_req_valid && $stable(slot_req_write) && $stable(slot_req_bit));
  // R4
  err_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && result[1:0] == 2'b11 |-> acc_cnt == 2'd2);
  // R6
  dir_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && result[1:0] != 2'b11 |-> acc_cnt == 2'd3 && wr_bit == result[2]);
  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !slot_req_valid);
  // R9
  keep_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));

endmodule

bind owts_search_step owts_search_step_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start          (start),
  .busy           (busy),
  .done           (done),
  .result         (result),
  .slot_req_valid (slot_req_valid),
  .slot_req_ready (slot_req_ready),
  .slot_req_write (slot_req_write),
  .slot_req_bit   (slot_req_bit)
);

// File: tb/sim_owts_search_step.sv
module sim_owts_search_step;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, pref_dir = 1'b0;
  logic busy, done;
  logic [2:0] result;
  logic slot_req_valid, slot_req_write, slot_req_bit;
  logic slot_req_ready = 1'b0, slot_rsp_valid = 1'b0, slot_rsp_bit = 1'b0;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  owts_search_step u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
    .busy(busy), .done(done), .result(result),
    .slot_req_valid(slot_req_valid), .slot_req_ready(slot_req_ready),
    .slot_req_write(slot_req_write), .slot_req_bit(slot_req_bit),
    .slot_rsp_valid(slot_rsp_valid), .slot_rsp_bit(slot_rsp_bit)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_res(logic id, logic cm, logic pref);
    if (id && cm)        return 3'b011;
    else if (!id && !cm) return {pref, 2'b00};
    else if (id)         return 3'b101;
    else                 return 3'b010;
  endfunction

  // serve one slot: wait for request, stall, accept, delay, respond
  task automatic serve(string req, logic exp_wr, logic exp_bit, logic rbit,
                       int stall, int lat, logic poke);
    int n = 0;
    logic w0, b0;
    while (!slot_req_valid && n < 50) begin
      chk("R3", {7'd0, done}, 8'd0);
      @(negedge clk); n++;
    end
    chk(req, {6'd0, slot_req_write, slot_req_bit}, {6'd0, exp_wr, exp_bit});
    w0 = slot_req_write; b0 = slot_req_bit;
    for (int i = 0; i < stall; i++) begin
      if (poke) begin start = 1'b1; pref_dir = ~pref_dir; end
      @(negedge clk);
      start = 1'b0;
      chk("R3", {5'd0, slot_req_valid, slot_req_write, slot_req_bit}, {5'd0, 1'b1, w0, b0});
    end
    slot_req_ready = 1'b1;
    @(negedge clk);
    slot_req_ready = 1'b0;
    for (int i = 0; i < lat; i++) begin
      chk("R3", {7'd0, slot_req_valid}, 8'd0);
      @(negedge clk);
    end
    slot_rsp_valid = 1'b1; slot_rsp_bit = rbit;
    @(negedge clk);
    slot_rsp_valid = 1'b0; slot_rsp_bit = 1'b0;
  endtask

  task automatic run_step(logic id, logic cm, logic pref, int stall, int lat, logic poke);
    logic [2:0] e;
    e = exp_res(id, cm, pref);
    start = 1'b1; pref_dir = pref;
    @(negedge clk);
    start = 1'b0;
    chk("R7", {7'd0, busy}, 8'd1);
    serve("R2", 1'b0, 1'b1, id, stall, lat, poke);
    serve("R2", 1'b0, 1'b1, cm, stall, lat, 1'b0);
    if (!(id && cm)) begin
      chk("R7", {7'd0, done}, 8'd0);
      serve(e[1:0] == 2'b00 ? "R5" : "R6", 1'b1, e[2], 1'b0, stall, lat, 1'b0);
    end
    // cycle after final response
    chk("R7", {6'd0, done, busy}, 8'd3);
    chk(id && cm ? "R4" : (id == cm ? "R5" : "R6"), {5'd0, result}, {5'd0, e});
    chk("R4", {7'd0, slot_req_valid}, 8'd0);
    @(negedge clk);
    chk("R7", {6'd0, done, busy}, 8'd0);
    pref_dir = ~pref_dir;
    repeat (2) @(negedge clk);
    chk("R9", {5'd0, result}, {5'd0, e});
    chk("R8", {7'd0, slot_req_valid}, 8'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    repeat (3) @(negedge clk);
    chk("R1", {3'd0, busy, done, slot_req_valid, 2'd0}, 8'd0);
    chk("R1", {5'd0, result}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {5'd0, busy, done, slot_req_valid}, 8'd0);
    // directed corners
    run_step(1'b1, 1'b1, 1'b1, 0, 0, 1'b0);   // R4 restart code
    run_step(1'b0, 1'b0, 1'b0, 2, 1, 1'b1);   // R5 pref 0, start poked R8
    run_step(1'b0, 1'b0, 1'b1, 3, 2, 1'b1);   // R5 pref 1, start poked R8
    run_step(1'b1, 1'b0, 1'b0, 1, 0, 1'b0);   // R6 -> 101
    run_step(1'b0, 1'b1, 1'b1, 0, 3, 1'b1);   // R6 -> 010
    run_step(1'b1, 1'b1, 1'b0, 4, 4, 1'b1);   // R4 with stalls
    for (int k = 0; k < 60; k++)
      run_step(1'($urandom), 1'($urandom), 1'($urandom),
               int'($urandom % 5), int'($urandom % 5), 1'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule